// File: doc/BRIEF.md
# Hardwired Stack-Accumulator Processor

This block is a small multicycle processor with hardwired control. It has a 16-bit accumulator, a 12-bit program counter and a 16-bit stack pointer. Each instruction word is 16 bits wide. The top four bits select the operation. For fifteen of the sixteen values, the low twelve bits are an operand X. This operand is a memory address, a jump target or an immediate constant. The sixteenth value opens an extended group. In that group, bits 11:8 select a stack, indirect, exchange, stack-adjust or stop operation, and bits 7:0 carry an 8-bit immediate where one is used.

The processor talks to a single-port synchronous memory of 4096 words. A read request is presented in one cycle, and the word comes back on the read-data input in the following cycle. A write completes at the clock edge that ends the request cycle. Each instruction takes a fetch cycle, a decode cycle and an execute cycle. Instructions that read a data word take one more cycle to consume it. After the stop instruction, the block raises `halted`. It then stays idle until reset.

Top module: `stackacc_cpu`

## Requirements
- R1: Reset clears the accumulator to 0, sets PC to 0 and SP to 1024, and clears `halted`. The first cycle after reset reads address 0.
- R2: Opcodes 0x0 to 0x3 act on Mem[X]: 0x0 loads it into AC, 0x1 stores AC to it, 0x2 adds it to AC and 0x3 subtracts it from AC. The result wraps modulo 2^16.
- R3: Opcode 0x7 loads X into AC, zero-extended to 16 bits.
- R4: Conditional jumps set PC to X. Opcode 0x4 jumps when AC[15] is 0. Opcode 0x5 jumps when AC is 0. Opcode 0xC jumps when AC[15] is 1. Opcode 0xD jumps when AC is not 0. Otherwise execution falls through to the next word.
- R5: Opcode 0x6 always sets PC to X.
- R6: Opcodes 0x8 to 0xB perform the load, store, add and subtract operations of R2 on Mem[(SP+X) mod 4096].
- R7: Opcode 0xE decrements SP, writes the address of the following instruction to Mem[SP], and sets PC to X. Word 0xF800 sets PC to Mem[SP] and then increments SP.
- R8: Word 0xF400 decrements SP and then writes AC to Mem[SP]. Word 0xF600 loads Mem[SP] into AC and then increments SP.
- R9: Word 0xF000 decrements SP and copies Mem[AC mod 4096] to Mem[SP]. Word 0xF200 copies Mem[SP] to Mem[AC mod 4096] and then increments SP.
- R10: A word with bits 15:8 equal to 0xFC adds the 8-bit field Y (bits 7:0) to SP. A word with bits 15:8 equal to 0xFE subtracts Y from SP. Both wrap modulo 2^16.
- R11: Word 0xFA00 exchanges AC and SP.
- R12: A word with bits 15:8 equal to 0xFF stops the processor. `halted` then stays high, and no memory access is requested until reset.
- R13: In the extended group, words whose bits 11:8 are 1, 3, 5, 7, 9, B or D change no register except PC, which advances by one as after every fetch.
- R14: A read and a write are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Word address of the current memory request |
| mem_re | output | 1 | Read request; data is expected on mem_rdata one cycle later |
| mem_we | output | 1 | Write request for mem_wdata at mem_addr |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_re |
| halted | output | 1 | High once the stop instruction has executed |

## Verification
Programs are assembled inside the bench, and their results are read back from memory after the processor halts.

- The direct add and subtract instructions are tried with operand pairs that include carry-out and borrow. This separates correct 16-bit wrapping from sign or width errors.
- Every conditional jump is swept against five accumulator values: zero, one, the largest positive value, the most negative value and all ones. This separates the sign test from the zero test.
- The stack-adjust immediates are swept over 0, 1, 0x80 and 0xFF in both directions, with a push used to reveal the resulting SP.
- Each undefined extended encoding is followed by a store and a push. A change to AC, SP or PC would then show up in memory.

// File: rtl/stackacc_pkg.sv
`timescale 1ns/1ps
package stackacc_pkg;

    parameter int WORD_W = 16;
    parameter int ADDR_W = 12;
    parameter int OPC_W  = WORD_W - ADDR_W;
    parameter int IMM_W  = 8;
    parameter int SUB_W  = ADDR_W - IMM_W;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_RDWAIT,
        ST_HALT
    } state_e;

    typedef enum logic [4:0] {
        OP_LD_DIR, OP_ST_DIR, OP_ADD_DIR, OP_SUB_DIR,
        OP_BR_NNEG, OP_BR_ZERO, OP_JMP, OP_LD_IMM,
        OP_LD_LOC, OP_ST_LOC, OP_ADD_LOC, OP_SUB_LOC,
        OP_BR_NEG, OP_BR_NZ, OP_CALL,
        OP_PUSH_IND, OP_POP_IND, OP_PUSH, OP_POP, OP_RET,
        OP_XCHG, OP_SP_ADD, OP_SP_SUB, OP_HALT, OP_NOP
    } op_e;

    typedef struct packed {
        state_e              state;
        logic [ADDR_W-1:0]   pc;
        logic [WORD_W-1:0]   ac;
        logic [WORD_W-1:0]   sp;
        logic [WORD_W-1:0]   ir;
    } core_t;

endpackage

// File: rtl/stackacc_decode.sv
`timescale 1ns/1ps
module stackacc_decode
    import stackacc_pkg::*;
(
    input  logic [WORD_W-1:0] ir,
    output op_e               op,
    output logic [ADDR_W-1:0] xfld,
    output logic [IMM_W-1:0]  imm
);
    logic [OPC_W-1:0] major;
    logic [SUB_W-1:0] minor;

    assign major = ir[WORD_W-1 -: OPC_W];
    assign minor = ir[ADDR_W-1 -: SUB_W];
    assign xfld  = ir[ADDR_W-1:0];
    assign imm   = ir[IMM_W-1:0];

    always_comb begin
        op = OP_NOP;
        if (major != {OPC_W{1'b1}}) begin
            op = op_e'({1'b0, major});
        end else begin
            case (minor)
                4'h0:    op = OP_PUSH_IND;
                4'h2:    op = OP_POP_IND;
                4'h4:    op = OP_PUSH;
                4'h6:    op = OP_POP;
                4'h8:    op = OP_RET;
                4'hA:    op = OP_XCHG;
                4'hC:    op = OP_SP_ADD;
                4'hE:    op = OP_SP_SUB;
                4'hF:    op = OP_HALT;
                default: op = OP_NOP;
            endcase
        end
    end
endmodule

// File: rtl/stackacc_alu.sv
`timescale 1ns/1ps
module stackacc_alu
    import stackacc_pkg::*;
(
    input  op_e               op,
    input  logic [WORD_W-1:0] ac,
    input  logic [WORD_W-1:0] mval,
    output logic [WORD_W-1:0] res,
    output logic              take
);
    logic ac_zero;
    logic ac_neg;

    assign ac_zero = (ac == '0);
    assign ac_neg  = ac[WORD_W-1];

    always_comb begin
        case (op)
            OP_ADD_DIR, OP_ADD_LOC: res = ac + mval;
            OP_SUB_DIR, OP_SUB_LOC: res = ac - mval;
            default:                res = mval;
        endcase
    end

    always_comb begin
        case (op)
            OP_BR_NNEG: take = !ac_neg;
            OP_BR_ZERO: take = ac_zero;
            OP_BR_NEG:  take = ac_neg;
            OP_BR_NZ:   take = !ac_zero;
            OP_JMP:     take = 1'b1;
            default:    take = 1'b0;
        endcase
    end
endmodule

// File: rtl/stackacc_cpu.sv
`timescale 1ns/1ps
module stackacc_cpu
    import stackacc_pkg::*;
#(
    parameter int PC_INIT = 0,
    parameter int SP_INIT = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [11:0]       mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic              halted
);
    localparam logic [ADDR_W-1:0] PC_RST = ADDR_W'(PC_INIT);
    localparam logic [WORD_W-1:0] SP_RST = WORD_W'(SP_INIT);

    core_t q, d;

    op_e               op;
    logic [ADDR_W-1:0] xfld;
    logic [IMM_W-1:0]  imm;
    logic [WORD_W-1:0] alu_res;
    logic              take;

    logic [WORD_W-1:0] sp_dec, sp_inc;
    logic [ADDR_W-1:0] loc_addr;

    stackacc_decode u_dec (
        .ir   (q.ir),
        .op   (op),
        .xfld (xfld),
        .imm  (imm)
    );

    stackacc_alu u_alu (
        .op   (op),
        .ac   (q.ac),
        .mval (mem_rdata),
        .res  (alu_res),
        .take (take)
    );

    assign sp_dec   = q.sp - 1'b1;
    assign sp_inc   = q.sp + 1'b1;
    assign loc_addr = q.sp[ADDR_W-1:0] + xfld;

    always_comb begin
        d         = q;
        mem_addr  = '0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        case (q.state)
            ST_FETCH: begin
                mem_addr = q.pc;
                mem_re   = 1'b1;
                d.state  = ST_DECODE;
            end
            ST_DECODE: begin
                d.ir    = mem_rdata;
                d.pc    = q.pc + 1'b1;
                d.state = ST_EXEC;
            end
            ST_EXEC: begin
                d.state = ST_FETCH;
                case (op)
                    OP_LD_DIR, OP_ADD_DIR, OP_SUB_DIR: begin
                        mem_addr = xfld;
                        mem_re   = 1'b1;
                        d.state  = ST_RDWAIT;
                    end
                    OP_LD_LOC, OP_ADD_LOC, OP_SUB_LOC: begin
                        mem_addr = loc_addr;
                        mem_re   = 1'b1;
                        d.state  = ST_RDWAIT;
                    end
                    OP_ST_DIR: begin
                        mem_addr  = xfld;
                        mem_we    = 1'b1;
                        mem_wdata = q.ac;
                    end
                    OP_ST_LOC: begin
                        mem_addr  = loc_addr;
                        mem_we    = 1'b1;
                        mem_wdata = q.ac;
                    end
                    OP_BR_NNEG, OP_BR_ZERO, OP_BR_NEG, OP_BR_NZ, OP_JMP: begin
                        if (take) d.pc = xfld;
                    end
                    OP_LD_IMM: d.ac = WORD_W'(xfld);
                    OP_CALL: begin
                        d.sp      = sp_dec;
                        mem_addr  = sp_dec[ADDR_W-1:0];
                        mem_we    = 1'b1;
                        mem_wdata = WORD_W'(q.pc);
                        d.pc      = xfld;
                    end
                    OP_PUSH_IND: begin
                        mem_addr = q.ac[ADDR_W-1:0];
                        mem_re   = 1'b1;
                        d.state  = ST_RDWAIT;
                    end
                    OP_POP_IND, OP_POP, OP_RET: begin
                        mem_addr = q.sp[ADDR_W-1:0];
                        mem_re   = 1'b1;
                        d.state  = ST_RDWAIT;
                    end
                    OP_PUSH: begin
                        d.sp      = sp_dec;
                        mem_addr  = sp_dec[ADDR_W-1:0];
                        mem_we    = 1'b1;
                        mem_wdata = q.ac;
                    end
                    OP_XCHG: begin
                        d.ac = q.sp;
                        d.sp = q.ac;
                    end
                    OP_SP_ADD: d.sp = q.sp + WORD_W'(imm);
                    OP_SP_SUB: d.sp = q.sp - WORD_W'(imm);
                    OP_HALT:   d.state = ST_HALT;
                    default: ;
                endcase
            end
            ST_RDWAIT: begin
                d.state = ST_FETCH;
                case (op)
                    OP_LD_DIR, OP_ADD_DIR, OP_SUB_DIR,
                    OP_LD_LOC, OP_ADD_LOC, OP_SUB_LOC: d.ac = alu_res;
                    OP_PUSH_IND: begin
                        d.sp      = sp_dec;
                        mem_addr  = sp_dec[ADDR_W-1:0];
                        mem_we    = 1'b1;
                        mem_wdata = mem_rdata;
                    end
                    OP_POP_IND: begin
                        mem_addr  = q.ac[ADDR_W-1:0];
                        mem_we    = 1'b1;
                        mem_wdata = mem_rdata;
                        d.sp      = sp_inc;
                    end
                    OP_POP: begin
                        d.ac = mem_rdata;
                        d.sp = sp_inc;
                    end
                    OP_RET: begin
                        d.pc = mem_rdata[ADDR_W-1:0];
                        d.sp = sp_inc;
                    end
                    default: ;
                endcase
            end
            ST_HALT: d.state = ST_HALT;
            default: d.state = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= ST_FETCH;
            q.pc    <= PC_RST;
            q.ac    <= '0;
            q.sp    <= SP_RST;
            q.ir    <= '0;
        end else begin
            q <= d;
        end
    end

    assign halted = (q.state == ST_HALT);

    assert_rw_excl_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_halt_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_re && !mem_we));

    assert_pc_step_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_DECODE) |=> (q.pc == ADDR_W'($past(q.pc) + 1'b1)));

    assert_push_sp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_EXEC && op == OP_PUSH) |=>
            (q.sp == WORD_W'($past(q.sp) - 1'b1)));

    assert_fetch_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_FETCH) |-> (mem_re && mem_addr == q.pc));
endmodule

// File: tb/sim_stackacc_cpu.sv
`timescale 1ns/1ps
module sim_stackacc_cpu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_re, mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        halted;

    logic [15:0] mem [0:4095];
    int checks = 0;
    int errors = 0;
    int both_cnt = 0;
    int wp = 0;
    bit done = 0;

    always #5 clk = ~clk;

    stackacc_cpu u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .halted(halted)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    always @(negedge clk) if (rst_n && mem_re && mem_we) both_cnt++;

    function automatic logic [15:0] ins(input logic [3:0] opc, input int x);
        return {opc, 12'(x)};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic start();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
        wp = 0;
    endtask

    task automatic emit(input logic [15:0] w);
        mem[wp] = w;
        wp++;
    endtask

    task automatic run();
        int cyc = 0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        while (!halted && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        if (!halted) chk("R12 halt reached", 16'(halted), 16'h1);
    endtask

    localparam logic [15:0] HALT = 16'hFF00;

    initial begin
        #(150000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] pa [6];
        logic [15:0] pb [6];
        logic [15:0] acv [5];
        logic [3:0]  bop [4];
        logic [7:0]  yv [4];
        logic [3:0]  undef [7];

        // R1: reset state observed at ports
        start();
        emit(HALT);
        @(negedge clk); #1;
        chk("R1 halted low in reset", 16'(halted), 16'h0);
        chk("R1 first read enable", 16'(mem_re), 16'h1);
        chk("R1 first read addr", 16'(mem_addr), 16'h0);
        run();
        chk("R12 halt word", 16'(halted), 16'h1);
        begin
            int act = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (mem_re || mem_we) act++;
                if (!halted) act++;
            end
            chk("R12 idle and sticky after halt", 16'(act), 16'h0);
        end
        // R1: reset clears halted
        @(negedge clk); rst_n = 1'b0; @(negedge clk); #1;
        chk("R1 reset clears halted", 16'(halted), 16'h0);

        // R2: direct add/sub sweep
        pa = '{16'h0003, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h0000, 16'h1234};
        pb = '{16'h0004, 16'h0001, 16'h8000, 16'h0001, 16'h0001, 16'h4321};
        for (int k = 0; k < 6; k++) begin
            start();
            emit(ins(4'h0, 100)); emit(ins(4'h2, 101)); emit(ins(4'h1, 102));
            emit(ins(4'h0, 100)); emit(ins(4'h3, 101)); emit(ins(4'h1, 103));
            emit(HALT);
            mem[100] = pa[k]; mem[101] = pb[k];
            run();
            chk("R2 direct add", mem[102], pa[k] + pb[k]);
            chk("R2 direct sub", mem[103], pa[k] - pb[k]);
        end

        // R3: load immediate
        for (int k = 0; k < 4; k++) begin
            int xv;
            xv = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 12'h7FF : 12'hFFF;
            start();
            emit(ins(4'h7, xv)); emit(ins(4'h1, 200)); emit(HALT);
            mem[200] = 16'hDEAD;
            run();
            chk("R3 load immediate", mem[200], 16'(xv));
        end

        // R4: conditional jumps against sign and zero
        acv = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
        bop = '{4'h4, 4'h5, 4'hC, 4'hD};
        for (int b = 0; b < 4; b++) begin
            for (int a = 0; a < 5; a++) begin
                bit tk;
                case (bop[b])
                    4'h4: tk = !acv[a][15];
                    4'h5: tk = (acv[a] == 0);
                    4'hC: tk = acv[a][15];
                    default: tk = (acv[a] != 0);
                endcase
                start();
                emit(ins(4'h0, 100)); emit(ins(bop[b], 10));
                emit(ins(4'h7, 1)); emit(ins(4'h1, 200)); emit(HALT);
                mem[10] = ins(4'h7, 2); mem[11] = ins(4'h1, 200); mem[12] = HALT;
                mem[100] = acv[a];
                run();
                chk("R4 conditional jump", mem[200], tk ? 16'd2 : 16'd1);
            end
        end

        // R5: unconditional jump
        start();
        emit(ins(4'h6, 10)); emit(ins(4'h7, 1)); emit(ins(4'h1, 200)); emit(HALT);
        mem[10] = ins(4'h7, 2); mem[11] = ins(4'h1, 200); mem[12] = HALT;
        run();
        chk("R5 jump taken", mem[200], 16'd2);

        // R6: SP-relative accesses from the reset SP
        start();
        emit(ins(4'h7, 5)); emit(ins(4'hA, 3)); emit(ins(4'h9, 4));
        emit(ins(4'h7, 9)); emit(ins(4'hB, 3)); emit(ins(4'h9, 5));
        emit(ins(4'h8, 4)); emit(ins(4'h1, 200)); emit(HALT);
        mem[1027] = 16'd10;
        run();
        chk("R6 local add store", mem[1028], 16'd15);
        chk("R6 local sub store", mem[1029], 16'hFFFF);
        chk("R6 local load", mem[200], 16'd15);

        // R11 and R6 wrap: SP set by exchange, local address wraps
        start();
        emit(ins(4'h7, 4000)); emit(16'hFA00); emit(ins(4'h1, 201));
        emit(ins(4'h7, 33)); emit(ins(4'h9, 200)); emit(HALT);
        run();
        chk("R11 exchange gives old SP", mem[201], 16'd1024);
        chk("R6 local address wraps", mem[104], 16'd33);

        // R11: exchange then push reveals SP
        start();
        emit(ins(4'h7, 9)); emit(16'hFA00); emit(16'hF400); emit(HALT);
        run();
        chk("R11 exchanged SP used by push", mem[8], 16'd1024);

        // R7: call and return
        start();
        emit(ins(4'hE, 20)); emit(ins(4'h7, 3)); emit(ins(4'h1, 201)); emit(HALT);
        mem[20] = ins(4'h7, 7); mem[21] = ins(4'h1, 200); mem[22] = 16'hF800;
        run();
        chk("R7 return address stacked", mem[1023], 16'd1);
        chk("R7 subroutine ran", mem[200], 16'd7);
        chk("R7 return resumed", mem[201], 16'd3);

        // R8: push and pop
        start();
        emit(ins(4'h7, 11)); emit(16'hF400); emit(ins(4'h7, 22)); emit(16'hF400);
        emit(16'hF600); emit(ins(4'h1, 200)); emit(16'hF600); emit(ins(4'h1, 201));
        emit(ins(4'h7, 44)); emit(16'hF400); emit(HALT);
        run();
        chk("R8 second push slot", mem[1022], 16'd22);
        chk("R8 pop order 1", mem[200], 16'd22);
        chk("R8 pop order 2", mem[201], 16'd11);
        chk("R8 SP restored by pops", mem[1023], 16'd44);

        // R9: indirect push and pop
        start();
        emit(ins(4'h7, 300)); emit(16'hF000); emit(ins(4'h7, 301)); emit(16'hF200);
        emit(ins(4'h7, 55)); emit(16'hF400); emit(HALT);
        mem[300] = 16'hABCD;
        run();
        chk("R9 indirect round trip", mem[301], 16'hABCD);
        chk("R9 SP back to reset value", mem[1023], 16'd55);

        // R10: stack adjust sweep
        yv = '{8'h00, 8'h01, 8'h80, 8'hFF};
        for (int k = 0; k < 4; k++) begin
            start();
            emit({8'hFE, yv[k]}); emit(ins(4'h7, 66)); emit(16'hF400); emit(HALT);
            run();
            chk("R10 subtract Y from SP", mem[1024 - int'(yv[k]) - 1], 16'd66);
            start();
            emit({8'hFC, yv[k]}); emit(ins(4'h7, 77)); emit(16'hF400); emit(HALT);
            run();
            chk("R10 add Y to SP", mem[1024 + int'(yv[k]) - 1], 16'd77);
        end

        // R13: undefined extended encodings are no-ops
        undef = '{4'h1, 4'h3, 4'h5, 4'h7, 4'h9, 4'hB, 4'hD};
        for (int k = 0; k < 7; k++) begin
            start();
            emit(ins(4'h7, 4)); emit({4'hF, undef[k], 8'h5A});
            emit(ins(4'h1, 200)); emit(16'hF400); emit(HALT);
            run();
            chk("R13 AC unchanged by undefined word", mem[200], 16'd4);
            chk("R13 SP unchanged by undefined word", mem[1023], 16'd4);
            chk("R13 execution continued to halt", 16'(halted), 16'h1);
        end

        // R14: never read and write together
        chk("R14 no simultaneous read and write", 16'(both_cnt), 16'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule